// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches eight asynchronous request pins of a small microcontroller. Each pin is brought into the clock domain, tested against a trigger condition chosen for that pin alone, and a hit is held in a per-pin sticky flag. Flags whose enable bit is set are merged onto two request lines that go to the CPU interrupt controller. Pins 0 to 3 drive the first line and pins 4 to 7 drive the second.

Software reaches three registers over a simple word bus. These are the trigger-select register, the enable register and the flag register. Each request line also has a service-mode input. In plain mode every trigger type is honoured. In transfer mode a hardware data mover serves the line, so only level triggers make sense there. A pin on such a line that is set to an edge trigger therefore behaves as the matching level trigger.

Top module: `ext_irq_detect`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every register reads zero and both request lines are low.
- R2: A pin is captured by two synchronizing flops. A trigger on the pin becomes visible in the flag register, and on the request line, right after the third rising clock edge that samples the new pin level.
- R3: The trigger select sits at address 0. Bits [2c+1:2c] belong to pin c. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge. Edges are found by comparing the synchronized value with its value one clock earlier.
- R4: The flag register sits at address 2, with bit c for pin c. Writing 0 to a bit clears it. Writing 1 leaves it unchanged.
- R5: If a clear and a new detection fall in the same cycle, the flag stays set. In a level mode the flag is set again on every clock in which the active level is still present.
- R6: The enable register sits at address 1, with bit c for pin c. `irq_o[0]` is the OR of flag AND enable over pins 0 to 3. `irq_o[1]` does the same over pins 4 to 7.
- R7: While `xfer_mode_i[l]` is 1, the pins of line l set to rising edge act as high level, and those set to falling edge act as low level.
- R8: Flags latch whether or not their enable bit is set. The enable bits gate only the request lines.
- R9: Reading address 3 returns zero. The upper eight read bits of addresses 1 and 2 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous external request pins |
| xfer_mode_i | input | 2 | Per-line service mode (1 = hardware transfer, levels only) |
| reg_addr_i | input | 2 | Register address (0 select, 1 enable, 2 flag) |
| reg_we_i | input | 1 | Write strobe, acts on the rising edge |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 2 | Request lines to the interrupt controller |

## Verification
Register writes take effect on the next edge, so read data and request lines reflect them in the following cycle. A pin change must pass two synchronizer edges and then the flag edge, so its result is due three edges after the pin is first sampled. The bench feeds every pin sample into a history queue inside its reference model, and draws the level and the previous level for detection from that queue at the right depth. The bench drives inputs on the falling edge, and it compares the request lines and the read data of the addressed register shortly after that falling edge. By then each register has settled on exactly one rising edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_SELECT = 2'd0,
        RA_ENABLE = 2'd1,
        RA_FLAG   = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic cur;
        logic old;
    } pin_samp_t;

    // Transfer-serviced lines only accept levels: map edges to their level.
    function automatic trig_e resolve_trig(trig_e t, logic xfer);
        trig_e r;
        r = t;
        if (xfer && t[1]) begin
            r = t[0] ? TRIG_LOW : TRIG_HIGH;
        end
        return r;
    endfunction

    function automatic logic trig_hit(trig_e t, pin_samp_t s);
        logic h;
        case (t)
            TRIG_LOW:  h = ~s.cur;
            TRIG_HIGH: h = s.cur;
            TRIG_RISE: h = s.cur & ~s.old;
            default:   h = ~s.cur & s.old;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync
    import ext_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        async_i,
    output pin_samp_t [W-1:0]   samp_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            old_q  <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            old_q  <= sync_q;
        end
    end

    for (genvar c = 0; c < W; c++) begin : g_pack
        assign samp_o[c].cur = sync_q[c];
        assign samp_o[c].old = old_q[c];
    end

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
    import ext_irq_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int N_LINES = 2
) (
    input  pin_samp_t [N_CH-1:0] samp_i,
    input  logic [2*N_CH-1:0]    select_i,
    input  logic [N_LINES-1:0]   xfer_mode_i,
    output logic [N_CH-1:0]      hit_o
);

    localparam int PER_LINE = N_CH / N_LINES;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam int LINE = c / PER_LINE;
        trig_e raw_t;
        trig_e eff_t;
        always_comb begin
            raw_t    = trig_e'(select_i[2*c +: 2]);
            eff_t    = resolve_trig(raw_t, xfer_mode_i[LINE]);
            hit_o[c] = trig_hit(eff_t, samp_i[c]);
        end
    end

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    input  logic [2*N_CH-1:0]    wdata_i,
    input  logic [N_CH-1:0]      hit_i,
    output logic [2*N_CH-1:0]    select_q,
    output logic [N_CH-1:0]      en_q,
    output logic [N_CH-1:0]      flag_q,
    output logic [2*N_CH-1:0]    rdata_o
);

    localparam int DW = 2 * N_CH;

    logic          wr_sel;
    logic          wr_en;
    logic          wr_flag;
    logic [N_CH-1:0] flag_nxt;

    assign wr_sel  = we_i && (addr_i == RA_SELECT);
    assign wr_en   = we_i && (addr_i == RA_ENABLE);
    assign wr_flag = we_i && (addr_i == RA_FLAG);

    // Clear by writing zero; a hit in the same cycle wins.
    always_comb begin
        flag_nxt = flag_q;
        if (wr_flag) begin
            flag_nxt = flag_nxt & wdata_i[N_CH-1:0];
        end
        flag_nxt = flag_nxt | hit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            select_q <= '0;
            en_q     <= '0;
            flag_q   <= '0;
        end else begin
            if (wr_sel) select_q <= wdata_i;
            if (wr_en)  en_q     <= wdata_i[N_CH-1:0];
            flag_q <= flag_nxt;
        end
    end

    always_comb begin
        case (addr_i)
            RA_SELECT: rdata_o = select_q;
            RA_ENABLE: rdata_o = {{(DW-N_CH){1'b0}}, en_q};
            RA_FLAG:   rdata_o = {{(DW-N_CH){1'b0}}, flag_q};
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int N_LINES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CH-1:0]      pin_i,
    input  logic [N_LINES-1:0]   xfer_mode_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_we_i,
    input  logic [2*N_CH-1:0]    reg_wdata_i,
    output logic [2*N_CH-1:0]    reg_rdata_o,
    output logic [N_LINES-1:0]   irq_o
);

    localparam int PER_LINE = N_CH / N_LINES;

    pin_samp_t [N_CH-1:0] samp;
    logic [N_CH-1:0]      hit;
    logic [2*N_CH-1:0]    select_q;
    logic [N_CH-1:0]      en_q;
    logic [N_CH-1:0]      flag_q;

    ext_irq_sync #(.W(N_CH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_i),
        .samp_o  (samp)
    );

    ext_irq_cond #(.N_CH(N_CH), .N_LINES(N_LINES)) u_cond (
        .samp_i      (samp),
        .select_i    (select_q),
        .xfer_mode_i (xfer_mode_i),
        .hit_o       (hit)
    );

    ext_irq_regs #(.N_CH(N_CH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (reg_addr_i),
        .we_i     (reg_we_i),
        .wdata_i  (reg_wdata_i),
        .hit_i    (hit),
        .select_q (select_q),
        .en_q     (en_q),
        .flag_q   (flag_q),
        .rdata_o  (reg_rdata_o)
    );

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        assign irq_o[l] = |(flag_q[l*PER_LINE +: PER_LINE] & en_q[l*PER_LINE +: PER_LINE]);
    end

endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
    import ext_irq_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int N_LINES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic                 reg_we_i,
    input logic [2*N_CH-1:0]    reg_wdata_i,
    input logic [2*N_CH-1:0]    reg_rdata_o,
    input logic [N_LINES-1:0]   irq_o,
    input logic [N_CH-1:0]      flag_q
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (irq_o == '0));

    assert_select_readback_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_we_i && reg_addr_i == RA_SELECT) |=>
            (reg_addr_i != RA_SELECT || reg_rdata_o == $past(reg_wdata_i)));

    assert_no_silent_clear_R4: assert property (@(posedge clk) disable iff (rst)
        !(reg_we_i && reg_addr_i == RA_FLAG) |=>
            ((flag_q & $past(flag_q)) == $past(flag_q)));

    assert_disable_silences_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_we_i && reg_addr_i == RA_ENABLE && reg_wdata_i[N_CH-1:0] == '0) |=>
            (irq_o == '0));

endmodule

bind ext_irq_detect ext_irq_chk #(.N_CH(N_CH), .N_LINES(N_LINES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .flag_q      (flag_q)
);

// File: tb/tb_ext_irq_detect.sv
module tb_ext_irq_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_i = '0;
    logic [1:0]  xfer_mode_i = '0;
    logic [1:0]  reg_addr_i = '0;
    logic        reg_we_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic [1:0]  irq_o;

    ext_irq_detect dut (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin_i),
        .xfer_mode_i (xfer_mode_i),
        .reg_addr_i  (reg_addr_i),
        .reg_we_i    (reg_we_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    always #2 clk = ~clk;

    int    n_vec  = 0;
    int    n_bad  = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    // Reference model: pin history queue plus architectural registers.
    logic [7:0]  hist[$] = '{8'h00, 8'h00, 8'h00};
    logic [15:0] m_sel  = '0;
    logic [7:0]  m_en   = '0;
    logic [7:0]  m_flag = '0;

    function automatic logic model_hit(logic [1:0] code, logic xfer, logic now_v, logic was_v);
        logic [1:0] k;
        k = code;
        if (xfer && k == 2'b10) k = 2'b01;
        if (xfer && k == 2'b11) k = 2'b00;
        if (k == 2'b00) return !now_v;
        if (k == 2'b01) return now_v;
        if (k == 2'b10) return now_v && !was_v;
        return !now_v && was_v;
    endfunction

    always @(posedge clk) begin
        logic [7:0] cur_s;
        logic [7:0] old_s;
        logic [7:0] nf;
        if (rst) begin
            m_sel = '0; m_en = '0; m_flag = '0;
            hist.push_back(8'h00);
        end else begin
            cur_s = hist[hist.size()-2];
            old_s = hist[hist.size()-3];
            nf = m_flag;
            if (reg_we_i && reg_addr_i == 2'd2) nf = nf & reg_wdata_i[7:0];
            for (int c = 0; c < 8; c++) begin
                if (model_hit(m_sel[2*c +: 2], xfer_mode_i[c/4], cur_s[c], old_s[c])) nf[c] = 1'b1;
            end
            if (reg_we_i && reg_addr_i == 2'd0) m_sel = reg_wdata_i;
            if (reg_we_i && reg_addr_i == 2'd1) m_en = reg_wdata_i[7:0];
            m_flag = nf;
            hist.push_back(pin_i);
        end
        void'(hist.pop_front());
    end

    task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always begin
        logic [1:0]  e_irq;
        logic [15:0] e_rd;
        @(negedge clk);
        #1;
        if (!done) begin
            e_irq = {|(m_flag[7:4] & m_en[7:4]), |(m_flag[3:0] & m_en[3:0])};
            case (reg_addr_i)
                2'd0: e_rd = m_sel;
                2'd1: e_rd = {8'h00, m_en};
                2'd2: e_rd = {8'h00, m_flag};
                default: e_rd = 16'h0000;
            endcase
            check(phase, "irq_o", {14'b0, irq_o}, {14'b0, e_irq});
            check(phase, "reg_rdata_o", reg_rdata_o, e_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            reg_addr_i = 2'(i);
        end
    endtask

    task automatic set_pins(input logic [7:0] v, input int hold);
        @(negedge clk);
        pin_i = v;
        idle(hold);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] lfsr;
        // R1: reset state visible while held and just after release
        idle(4);
        rst = 1'b0;
        idle(4);

        // R3 / R6: one pin per code on line 0, all codes again on line 1
        phase = "R3";
        wr(2'd0, 16'b11_10_01_00_11_10_01_00);
        wr(2'd1, 16'h00FF);
        wr(2'd2, 16'h0000);
        set_pins(8'h00, 6);
        wr(2'd2, 16'h0000);
        set_pins(8'hFF, 6);
        wr(2'd2, 16'h0000);
        set_pins(8'h00, 6);

        // R2: single pin rises with only that pin enabled, latency observed
        phase = "R2";
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'h0002);
        wr(2'd2, 16'h0000);
        set_pins(8'h02, 6);

        // R4: clear patterns with all pins inactive for high level
        phase = "R4";
        set_pins(8'h00, 2);
        wr(2'd2, 16'h00F0);
        idle(3);
        wr(2'd2, 16'h00FF);
        idle(3);
        wr(2'd2, 16'h0000);
        idle(3);

        // R5: clear while level still present, then edge latched and cleared
        phase = "R5";
        set_pins(8'h11, 5);
        wr(2'd2, 16'h0000);
        idle(3);
        wr(2'd0, 16'hAAAA);
        set_pins(8'h00, 4);
        wr(2'd2, 16'h0000);
        set_pins(8'h44, 5);
        wr(2'd2, 16'h0000);
        idle(3);

        // R6: enable masks per line
        phase = "R6";
        wr(2'd0, 16'h5555);
        set_pins(8'h81, 4);
        wr(2'd1, 16'h0001);
        idle(3);
        wr(2'd1, 16'h0080);
        idle(3);
        wr(2'd1, 16'h0000);
        idle(3);

        // R8: flags collect with enables off
        phase = "R8";
        wr(2'd2, 16'h0000);
        set_pins(8'h3C, 5);
        wr(2'd1, 16'h00FF);
        idle(3);

        // R7: transfer mode turns edges into levels on the chosen line
        phase = "R7";
        wr(2'd0, 16'b11_10_11_10_11_10_11_10);
        set_pins(8'h00, 4);
        wr(2'd2, 16'h0000);
        xfer_mode_i = 2'b01;
        set_pins(8'h55, 6);
        wr(2'd2, 16'h0000);
        idle(3);
        xfer_mode_i = 2'b10;
        wr(2'd2, 16'h0000);
        set_pins(8'hAA, 6);
        wr(2'd2, 16'h0000);
        idle(3);
        xfer_mode_i = 2'b00;

        // R9: spare address and zero upper read bits
        phase = "R9";
        wr(2'd1, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        idle(8);

        // R3: pseudo-random pins, mixed codes, modes and clears
        phase = "R3";
        lfsr = 8'hA5;
        wr(2'd0, 16'h1BE4);
        for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            @(negedge clk);
            pin_i = lfsr;
            xfer_mode_i = lfsr[1:0];
            reg_addr_i = lfsr[3:2];
            reg_we_i = (lfsr[6:4] == 3'b101);
            reg_wdata_i = {lfsr, ~lfsr};
        end
        @(negedge clk);
        reg_we_i = 1'b0;
        idle(4);
        finish_run();
    end

endmodule